// File: doc/BRIEF.md
# Offset Min-Sum Check Node

This unit is the shared check-node stage of a column-parallel LDPC decoder. Each step it takes one signed variable-to-check message from every block-column processing element, along with a per-column enable. The enable is cleared for a column whose submatrix in the current block row is all zero. The unit returns one extrinsic message to every column, and all columns receive their results in the same cycle.

Each extrinsic follows the offset min-sum rule, taken over the enabled inputs other than the receiving one. Its magnitude is the smallest magnitude among those other inputs, reduced by a run-time offset and clamped at zero. Its sign is the product of their signs. The unit finds the smallest magnitude, the second-smallest magnitude and the position of the smallest, so each column can be served without a separate reduction per column. The result passes through a fixed number of register stages, and a valid flag travels with it.

Top module: `min_sum_check_node`

## Requirements
- R1: While reset is held and after it is released, with no input presented, `out_valid` is 0 and `out_msg` is all zeros.
- R2: Messages are MW-bit two's complement values. Column i occupies bits [i*MW +: MW] of `in_msg` and of `out_msg`. A message's magnitude is its absolute value, and the most negative code is treated as magnitude 2^(MW-1)-1. With a zero offset, an enabled column receives the smallest magnitude found among the other enabled columns.
- R3: When two or more enabled columns share the smallest magnitude, every enabled column, including those tied columns, receives that magnitude.
- R4: The output magnitude is the value from R2 minus `offset`, floored at zero. An offset equal to or above that value gives an output of 0.
- R5: An output is negative (two's complement) when an odd number of the other enabled columns carry negative messages, and non-negative otherwise. An output magnitude of zero is always sent as 0.
- R6: A column with its `in_en` bit at 0 does not take part in the minimum or the sign of any other column, and it receives 0.
- R7: A column that is the only enabled one receives +(2^(MW-1)-1-offset), floored at 0. With no column enabled, every output is 0.
- R8: `out_valid` rises exactly LAT cycles after the cycle in which `in_valid` was sampled high, for one cycle per input. Inputs may arrive on consecutive cycles, and each result keeps to its own input.
- R9: The offset that applies is the one sampled together with the inputs. A later change to `offset` does not affect results already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new set of column messages is present |
| in_en | input | NB | Per-column participation enable |
| in_msg | input | NB*MW | Packed signed variable-to-check messages |
| offset | input | MW-1 | Run-time offset subtracted from output magnitudes |
| out_valid | output | 1 | Extrinsic results are present |
| out_msg | output | NB*MW | Packed signed check-to-variable extrinsics |

## Verification
The bench builds the unit with six columns, 5-bit messages and three pipeline stages. Six columns allow disabled positions on both sides of the minimum, ties between the minimum and the second minimum, and sign parities of both polarities. Three stages leave room to change the offset while a result is still in flight and to stream back-to-back inputs with several results pending at once. With 5-bit messages the most negative code -16, full-range offsets up to 15 and the single-enabled-input case all fall inside small, hand-checkable values.

// File: rtl/msc_pkg.sv
package msc_pkg;

    parameter int MSC_NB_DEF  = 6;
    parameter int MSC_MW_DEF  = 5;
    parameter int MSC_LAT_DEF = 3;

endpackage

// File: rtl/msc_split.sv
module msc_split #(
    parameter int MW = msc_pkg::MSC_MW_DEF
) (
    input  logic [MW-1:0] msg,
    output logic          neg,
    output logic [MW-2:0] mag
);
    localparam logic [MW-1:0] MOST_NEG = {1'b1, {(MW-1){1'b0}}};

    logic [MW-1:0] flipped;

    always_comb begin
        neg     = msg[MW-1];
        flipped = -msg;
        if (!neg)
            mag = msg[MW-2:0];
        else if (msg == MOST_NEG)
            mag = '1;
        else
            mag = flipped[MW-2:0];
    end
endmodule

// File: rtl/msc_min2.sv
module msc_min2 #(
    parameter int NB   = msc_pkg::MSC_NB_DEF,
    parameter int MAGW = msc_pkg::MSC_MW_DEF - 1,
    parameter int IDXW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB*MAGW-1:0] mags,
    input  logic [NB-1:0]      en,
    output logic [MAGW-1:0]    min1,
    output logic [MAGW-1:0]    min2,
    output logic [IDXW-1:0]    idx,
    output logic               any
);
    always_comb begin
        min1 = '1;
        min2 = '1;
        idx  = '0;
        any  = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (en[i]) begin
                if (!any || mags[i*MAGW +: MAGW] < min1) begin
                    min2 = min1;
                    min1 = mags[i*MAGW +: MAGW];
                    idx  = IDXW'(i);
                end else if (mags[i*MAGW +: MAGW] < min2) begin
                    min2 = mags[i*MAGW +: MAGW];
                end
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msc_outsel.sv
module msc_outsel #(
    parameter int MW = msc_pkg::MSC_MW_DEF
) (
    input  logic          en,
    input  logic          own_neg,
    input  logic          parity,
    input  logic          is_min,
    input  logic [MW-2:0] min1,
    input  logic [MW-2:0] min2,
    input  logic [MW-2:0] ofs,
    output logic [MW-1:0] msg_out
);
    logic [MW-2:0] sel;
    logic [MW-2:0] red;
    logic          neg_out;

    always_comb begin
        sel     = is_min ? min2 : min1;
        red     = (sel > ofs) ? (sel - ofs) : '0;
        neg_out = parity ^ own_neg;
        if (!en || red == '0)
            msg_out = '0;
        else if (neg_out)
            msg_out = -{1'b0, red};
        else
            msg_out = {1'b0, red};
    end
endmodule

// File: rtl/msc_pipe.sv
module msc_pipe #(
    parameter int W   = 30,
    parameter int LAT = msc_pkg::MSC_LAT_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } stage_t;

    stage_t st_d [LAT];
    stage_t st_q [LAT];

    always_comb begin
        st_d[0].vld = in_valid;
        st_d[0].dat = in_data;
        for (int s = 1; s < LAT; s++)
            st_d[s] = st_q[s-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < LAT; s++)
                st_q[s] <= '0;
        end else begin
            for (int s = 0; s < LAT; s++)
                st_q[s] <= st_d[s];
        end
    end

    assign out_valid = st_q[LAT-1].vld;
    assign out_data  = st_q[LAT-1].dat;
endmodule

// File: rtl/min_sum_check_node.sv
module min_sum_check_node #(
    parameter int NB  = msc_pkg::MSC_NB_DEF,
    parameter int MW  = msc_pkg::MSC_MW_DEF,
    parameter int LAT = msc_pkg::MSC_LAT_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [NB-1:0]   in_en,
    input  logic [NB*MW-1:0] in_msg,
    input  logic [MW-2:0]   offset,
    output logic            out_valid,
    output logic [NB*MW-1:0] out_msg
);
    localparam int MAGW = MW - 1;
    localparam int IDXW = (NB > 1) ? $clog2(NB) : 1;
    localparam int PW   = $clog2(LAT + 2);
    localparam logic [MAGW-1:0] MAXMAG = '1;

    logic [NB-1:0]        neg_v;
    logic [NB*MAGW-1:0]   mag_v;
    logic [MAGW-1:0]      mag_a [NB];
    logic [MAGW-1:0]      min1, min2;
    logic [IDXW-1:0]      idx;
    logic                 any;
    logic                 parity;
    logic [NB*MW-1:0]     ext_v;

    for (genvar i = 0; i < NB; i++) begin : g_col
        msc_split #(.MW(MW)) u_split (
            .msg (in_msg[i*MW +: MW]),
            .neg (neg_v[i]),
            .mag (mag_v[i*MAGW +: MAGW])
        );
        assign mag_a[i] = mag_v[i*MAGW +: MAGW];

        msc_outsel #(.MW(MW)) u_out (
            .en      (in_en[i]),
            .own_neg (neg_v[i]),
            .parity  (parity),
            .is_min  (idx == IDXW'(i)),
            .min1    (min1),
            .min2    (min2),
            .ofs     (offset),
            .msg_out (ext_v[i*MW +: MW])
        );
    end

    assign parity = ^(neg_v & in_en);

    msc_min2 #(.NB(NB), .MAGW(MAGW), .IDXW(IDXW)) u_tree (
        .mags (mag_v),
        .en   (in_en),
        .min1 (min1),
        .min2 (min2),
        .idx  (idx),
        .any  (any)
    );

    msc_pipe #(.W(NB*MW), .LAT(LAT)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (ext_v),
        .out_valid (out_valid),
        .out_data  (out_msg)
    );

    // Checker state: results entered but not yet delivered.
    logic [PW-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q + PW'(in_valid) - PW'(out_valid);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R2: the tree orders its two survivors
    a_r2_min_order: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (min1 <= min2));

    // R2: the reported index is an enabled column that holds the minimum
    a_r2_min_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any) |-> (in_en[idx] && mag_a[idx] == min1));

    // R7: with nothing enabled the tree reports the ceiling
    a_r7_empty_tree: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any) |-> (min1 == MAXMAG && min2 == MAXMAG));

    // R8: never more results in flight than pipeline stages
    a_r8_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PW'(LAT));

    // R8: no result leaves without a matching input
    a_r8_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pend_q != '0));

    // R1: nothing emerges in the cycle right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/tb_min_sum_check_node.sv
`timescale 1ns/1ps
module tb_min_sum_check_node;
    localparam int NB  = 6;
    localparam int MW  = 5;
    localparam int LAT = 3;
    localparam int NT  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [NB-1:0]   in_en = '0;
    logic [NB*MW-1:0] in_msg = '0;
    logic [MW-2:0]   offset = '0;
    logic            out_valid;
    logic [NB*MW-1:0] out_msg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    min_sum_check_node #(.NB(NB), .MW(MW), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_en(in_en),
        .in_msg(in_msg), .offset(offset), .out_valid(out_valid), .out_msg(out_msg)
    );

    localparam int TAB_MSG [NT][NB] = '{
        '{  1,   2,   3,   4,  5,  6},
        '{ -1,  -2,  -3,  -4, -5, -6},
        '{  0,   7,  -7,   8, -8, 15},
        '{-16,  15, -15,  14,  3, -3},
        '{  5,   5,   5,   5,  5,  5},
        '{  9,  -1,   0,  12, -4,  6},
        '{ -8,   8,  -8,   8, -8,  8},
        '{ 11, -12,  13, -14, 10, -9}
    };
    localparam logic [NB-1:0] TAB_EN [NT] = '{
        6'b111111, 6'b111111, 6'b111111, 6'b101101,
        6'b111111, 6'b011010, 6'b100001, 6'b111111
    };
    localparam int TAB_OFS [NT] = '{0, 1, 0, 2, 3, 0, 4, 10};

    function automatic logic [NB*MW-1:0] pk(int a, int b, int c, int d, int e, int f);
        return {MW'(f), MW'(e), MW'(d), MW'(c), MW'(b), MW'(a)};
    endfunction

    // Reference: per column, scan every other enabled column directly.
    function automatic logic [NB*MW-1:0] ref_ext(int m [NB], logic [NB-1:0] en, int ofs);
        logic [NB*MW-1:0] r = '0;
        for (int i = 0; i < NB; i++) begin
            int best = 15;
            int sgn  = 0;
            int v;
            if (!en[i]) continue;
            for (int j = 0; j < NB; j++) begin
                int a;
                if (j == i || !en[j]) continue;
                a = (m[j] < 0) ? -m[j] : m[j];
                if (a > 15) a = 15;
                if (a < best) best = a;
                if (m[j] < 0) sgn ^= 1;
            end
            v = best - ofs;
            if (v < 0) v = 0;
            if (sgn == 1) v = -v;
            r[i*MW +: MW] = MW'(v);
        end
        return r;
    endfunction

    task automatic check(string req, logic [NB*MW-1:0] act, logic [NB*MW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic one_shot(string req, logic [NB-1:0] en, logic [NB*MW-1:0] m,
                            int ofs, logic [NB*MW-1:0] exp);
        @(negedge clk);
        in_en = en; in_msg = m; offset = (MW-1)'(ofs); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT-1) @(negedge clk);
        check({req, " valid"}, {{(NB*MW-1){1'b0}}, out_valid}, 1);
        check(req, out_msg, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NB*MW-1:0] exp_q [NT];
        logic [NB*MW-1:0] va;

        repeat (3) @(negedge clk);
        check("R1 reset valid", {{(NB*MW-1){1'b0}}, out_valid}, 0);
        check("R1 reset data", out_msg, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", {{(NB*MW-1){1'b0}}, out_valid}, 0);

        // Table, streamed back to back
        for (int k = 0; k < NT + LAT; k++) begin
            @(negedge clk);
            if (k >= LAT) begin
                check("R8 stream valid", {{(NB*MW-1){1'b0}}, out_valid}, 1);
                check("R2 R5 stream data", out_msg, exp_q[k-LAT]);
            end
            if (k < NT) begin
                int mm [NB];
                for (int c = 0; c < NB; c++) mm[c] = TAB_MSG[k][c];
                in_en    = TAB_EN[k];
                in_msg   = pk(mm[0], mm[1], mm[2], mm[3], mm[4], mm[5]);
                offset   = (MW-1)'(TAB_OFS[k]);
                in_valid = 1'b1;
                exp_q[k] = ref_ext(mm, TAB_EN[k], TAB_OFS[k]);
            end else begin
                in_valid = 1'b0;
            end
        end

        va = pk(3, -5, 7, 2, -9, 4);
        one_shot("R2 R5 basic", 6'b111111, va, 0, pk(2, -2, 2, 3, -2, 2));
        one_shot("R4 offset1", 6'b111111, va, 1, pk(1, -1, 1, 2, -1, 1));
        one_shot("R4 offset floor", 6'b111111, va, 15, '0);
        one_shot("R6 disabled", 6'b110110, va, 0, pk(0, -4, 4, 0, -4, 5));
        one_shot("R3 tie", 6'b111111, pk(4, 4, 9, -10, 12, 6), 0,
                 pk(-4, -4, -4, 4, -4, -4));
        one_shot("R7 single", 6'b000100, pk(0, 0, -6, 0, 0, 0), 2,
                 pk(0, 0, 13, 0, 0, 0));
        one_shot("R7 none", 6'b000000, va, 0, '0);
        one_shot("R2 most negative", 6'b000011, pk(-16, -16, 0, 0, 0, 0), 0,
                 pk(-15, -15, 0, 0, 0, 0));

        // R9: offset changes while the result is in flight
        @(negedge clk);
        in_en = 6'b111111; in_msg = va; offset = 4'd1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; offset = 4'd7;
        repeat (LAT-1) @(negedge clk);
        check("R9 offset held", out_msg, pk(1, -1, 1, 2, -1, 1));

        // R8: exact latency of a lone input
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT-2) @(negedge clk);
        check("R8 before", {{(NB*MW-1){1'b0}}, out_valid}, 0);
        @(negedge clk);
        check("R8 at", {{(NB*MW-1){1'b0}}, out_valid}, 1);
        @(negedge clk);
        check("R8 after", {{(NB*MW-1){1'b0}}, out_valid}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule